// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block is the interrupt front end of a clock and reset control peripheral. It keeps a small status register that event sources set through a hardware input, and a mask register that decides which status bits may reach the single level-sensitive interrupt output. Software clears status bits by writing ones to them. It changes the mask only through two write-only command words: one unmasks bits, the other masks them. The mask word can be read but cannot be written directly.

The register port is a plain 32-bit word bus with an address, a write strobe, write data and combinational read data. Only aligned word addresses decode. The word offsets are status at 0x0, mask at 0x4, unmask command at 0x8 and mask command at 0xC. The width of the status and mask words is a parameter, `NUM_BITS`, and each word occupies the low bits of its 32-bit register.

Top module: `ism_ctl`

## Requirements
- R1: After reset the status word is all zero, every mask bit is one, and `irq_o` is low.
- R2: `irq_o` is high exactly when some status bit is one and its mask bit is zero. It follows any change of either word within the same cycle as the clock edge that made the change.
- R3: A write to offset 0x0 clears each status bit whose `wr_data` bit is one. Status bits whose `wr_data` bit is zero keep their value.
- R4: A one on `evt_set[i]` sets status bit i at the next clock edge. If a clearing write to the same bit happens in the same cycle, the bit ends up set.
- R5: A write to the mask word at offset 0x4 has no effect on the mask.
- R6: A write to offset 0x8 clears each mask bit whose `wr_data` bit is one. The other mask bits are left unchanged.
- R7: A write to offset 0xC sets each mask bit whose `wr_data` bit is one. The other mask bits are left unchanged.
- R8: A read at offset 0x8 or 0xC returns zero.
- R9: A read at offset 0x0 returns the status word in bits NUM_BITS-1:0, and a read at offset 0x4 returns the mask word there. All higher bits read as zero.
- R10: A read from an unmapped or non-word-aligned address returns zero. A write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `bus_addr`, combinational |
| evt_set | input | NUM_BITS | Hardware set request, one bit per status bit |
| irq_o | output | 1 | Level interrupt output |

## Verification
A corrupted status or mask bit appears at the ports in two ways. It shows on `irq_o` in the cycle after the edge that corrupted it, but only when the partner bit allows it to pass. It also shows on `rd_data` as soon as the word is addressed. For that reason the bench reads both words back after each write and compares `irq_o` at the same moment. It covers the cases where a masked bit hides a wrong status value and where a command word with zero bits must leave the mask unchanged. The race between a clearing write and a hardware set is driven in a single cycle, and the result is read back at once.

// File: rtl/ism_pkg.sv
package ism_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_MASK,
    SEL_UNMASK,
    SEL_DOMASK
  } reg_sel_e;

  // Word indices (byte offset >> 2)
  localparam int unsigned IDX_STAT   = 0;
  localparam int unsigned IDX_MASK   = 1;
  localparam int unsigned IDX_UNMASK = 2;
  localparam int unsigned IDX_DOMASK = 3;

  // Next status: clear requested ones, then let hardware sets win
  function automatic logic [31:0] stat_next(input logic [31:0] cur,
                                            input logic [31:0] clr,
                                            input logic [31:0] set);
    return (cur & ~clr) | set;
  endfunction

  // Next mask: unmask bits drop, mask bits rise
  function automatic logic [31:0] mask_next(input logic [31:0] cur,
                                            input logic [31:0] unm,
                                            input logic [31:0] msk);
    return (cur & ~unm) | msk;
  endfunction

  function automatic logic pending(input logic [31:0] st,
                                  input logic [31:0] mk);
    return |(st & ~mk);
  endfunction

endpackage

// File: rtl/ism_decode.sv
module ism_decode
  import ism_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output reg_sel_e          sel,
  output logic              clr_stb,
  output logic              unmask_stb,
  output logic              domask_stb
);
  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] idx;

  assign aligned = (addr[1:0] == 2'b00);
  assign idx     = addr[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if (idx == IDX_W'(IDX_STAT))        sel = SEL_STAT;
      else if (idx == IDX_W'(IDX_MASK))   sel = SEL_MASK;
      else if (idx == IDX_W'(IDX_UNMASK)) sel = SEL_UNMASK;
      else if (idx == IDX_W'(IDX_DOMASK)) sel = SEL_DOMASK;
    end
  end

  assign clr_stb    = we && (sel == SEL_STAT);
  assign unmask_stb = we && (sel == SEL_UNMASK);
  assign domask_stb = we && (sel == SEL_DOMASK);
endmodule

// File: rtl/ism_status.sv
module ism_status
  import ism_pkg::*;
#(
  parameter int NUM_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_stb,
  input  logic [NUM_BITS-1:0] clr_bits,
  input  logic [NUM_BITS-1:0] set_bits,
  output logic [NUM_BITS-1:0] status
);
  logic [NUM_BITS-1:0] clr_eff;
  logic [31:0]         nxt;

  assign clr_eff = clr_stb ? clr_bits : '0;
  assign nxt     = stat_next(32'(status), 32'(clr_eff), 32'(set_bits));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= nxt[NUM_BITS-1:0];
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits != '0) |=> ((status & $past(set_bits)) == $past(set_bits))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && ((clr_bits & ~set_bits) != '0))
      |=> ((status & $past(clr_bits & ~set_bits)) == '0)); // R3
  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_stb && (set_bits == '0)) |=> $stable(status)); // R10
endmodule

// File: rtl/ism_mask.sv
module ism_mask
  import ism_pkg::*;
#(
  parameter int NUM_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                unmask_stb,
  input  logic                domask_stb,
  input  logic [NUM_BITS-1:0] bits,
  output logic [NUM_BITS-1:0] mask
);
  logic [NUM_BITS-1:0] unm, msk;
  logic [31:0]         nxt;

  assign unm = unmask_stb ? bits : '0;
  assign msk = domask_stb ? bits : '0;
  assign nxt = mask_next(32'(mask), 32'(unm), 32'(msk));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '1;
    else        mask <= nxt[NUM_BITS-1:0];
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!unmask_stb && !domask_stb) |=> $stable(mask)); // R5
  AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_stb |=> ((mask & $past(bits)) == '0)); // R6
  AST_UNMASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_stb |=> ((mask & ~$past(bits)) == ($past(mask) & ~$past(bits)))); // R6
  AST_DOMASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    domask_stb |=> ((mask & $past(bits)) == $past(bits))); // R7
endmodule

// File: rtl/ism_ctl.sv
module ism_ctl
  import ism_pkg::*;
#(
  parameter int NUM_BITS = 4,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         wr_data,
  output logic [31:0]         rd_data,
  input  logic [NUM_BITS-1:0] evt_set,
  output logic                irq_o
);
  reg_sel_e            sel;
  logic                clr_stb, unmask_stb, domask_stb;
  logic [NUM_BITS-1:0] status, mask;

  ism_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr       (bus_addr),
    .we         (bus_we),
    .sel        (sel),
    .clr_stb    (clr_stb),
    .unmask_stb (unmask_stb),
    .domask_stb (domask_stb)
  );

  ism_status #(.NUM_BITS(NUM_BITS)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_stb  (clr_stb),
    .clr_bits (wr_data[NUM_BITS-1:0]),
    .set_bits (evt_set),
    .status   (status)
  );

  ism_mask #(.NUM_BITS(NUM_BITS)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .unmask_stb (unmask_stb),
    .domask_stb (domask_stb),
    .bits       (wr_data[NUM_BITS-1:0]),
    .mask       (mask)
  );

  assign irq_o = pending(32'(status), 32'(mask));

  always_comb begin
    case (sel)
      SEL_STAT: rd_data = 32'(status);
      SEL_MASK: rd_data = 32'(mask);
      default:  rd_data = '0;
    endcase
  end

  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel == SEL_UNMASK) || (sel == SEL_DOMASK)) |-> (rd_data == '0)); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (rd_data == '0)); // R10
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq_o); // R2
endmodule

// File: tb/tb_ism_ctl.sv
module tb_ism_ctl;
  localparam int N  = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [N-1:0]  evt_set = '0;
  logic [31:0]   rd_data;
  logic          irq_o;

  always #2 clk = ~clk;  // 250 MHz

  ism_ctl #(.NUM_BITS(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .wr_data(wr_data), .rd_data(rd_data), .evt_set(evt_set), .irq_o(irq_o)
  );

  typedef struct {
    string       req;
    logic [31:0] exp_rd;
    logic        exp_irq;
  } item_t;

  item_t        q[$];
  event         smp;
  int           compared = 0;
  int           mismatched = 0;
  bit           done = 1'b0;
  logic [N-1:0] m_st, m_mk;

  // Monitor: pops one expected item per sample event
  initial begin
    item_t it;
    forever begin
      @(smp);
      #1;
      it = q.pop_front();
      compared++;
      if (rd_data !== it.exp_rd) begin
        mismatched++;
        $display("FAIL %s rd_data actual=%h expected=%h", it.req, rd_data, it.exp_rd);
      end
      compared++;
      if (irq_o !== it.exp_irq) begin
        mismatched++;
        $display("FAIL %s irq_o actual=%b expected=%b", it.req, irq_o, it.exp_irq);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [N-1:0] s);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; wr_data = d; evt_set = s;
    @(negedge clk);
    bus_we = 1'b0; wr_data = '0; evt_set = '0;
    if (a[1:0] == 2'b00) begin
      case (a[AW-1:2])
        6'd0: m_st = m_st & ~d[N-1:0];
        6'd2: m_mk = m_mk & ~d[N-1:0];
        6'd3: m_mk = m_mk | d[N-1:0];
        default: ;
      endcase
    end
    m_st = m_st | s;
  endtask

  task automatic chk(input logic [AW-1:0] a, input string req);
    item_t it;
    it.req = req;
    it.exp_rd = '0;
    if (a == 8'h00)      it.exp_rd = 32'(m_st);
    else if (a == 8'h04) it.exp_rd = 32'(m_mk);
    it.exp_irq = |(m_st & ~m_mk);
    q.push_back(it);
    bus_addr = a;
    ->smp;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    m_st = '0; m_mk = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(8'h00, "R1 status after reset");
    chk(8'h04, "R1 mask after reset");
    // Hardware set while masked
    wr(8'h40, 32'h0, 4'b0010);  // unmapped write carries the set
    chk(8'h00, "R4 hw set reaches status, R10 unmapped write");
    chk(8'h04, "R2 masked bit keeps irq low");
    // Direct mask write ignored
    wr(8'h04, 32'h0, '0);
    chk(8'h04, "R5 mask write ignored");
    // Unmask with zero bits
    wr(8'h08, 32'h0, '0);
    chk(8'h04, "R6 zero unmask keeps mask");
    wr(8'h08, 32'h2, '0);
    chk(8'h04, "R6 unmask bit1, R2 irq rises");
    chk(8'h08, "R8 unmask reads zero");
    chk(8'h0C, "R8 mask command reads zero");
    // W1C with zero
    wr(8'h00, 32'hFFFF_FFF0, '0);
    chk(8'h00, "R3 zero bits keep status, R9 upper zero");
    wr(8'h00, 32'h2, '0);
    chk(8'h00, "R3 w1c clears bit1, R2 irq falls");
    // Race: set and clear of bit 2 together
    wr(8'h00, 32'h4, 4'b0100);
    chk(8'h00, "R4 set wins over clear");
    wr(8'h08, 32'h4, '0);
    chk(8'h04, "R6 unmask bit2, R2 irq high");
    wr(8'h0C, 32'h0, '0);
    chk(8'h04, "R7 zero mask command keeps mask");
    wr(8'h0C, 32'h4, '0);
    chk(8'h04, "R7 mask bit2, R2 irq low");
    // Unaligned and unmapped
    wr(8'h09, 32'hF, '0);
    chk(8'h04, "R10 unaligned write ignored");
    chk(8'h01, "R10 unaligned read zero");
    chk(8'h10, "R10 unmapped read zero");
    chk(8'h00, "R9 status readback");
    // Reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_st = '0; m_mk = '1;
    chk(8'h00, "R1 status after second reset");
    chk(8'h04, "R1 mask after second reset");
    done = 1'b1;
    #1;
    summary();
    $finish;
  end
endmodule